// File: doc/BRIEF.md
# Event-Synchronized Register Command Engine

This block runs a short program of 64-bit commands kept in a command memory and turns them into register writes on a simple register-bus master port. Software supplies a byte address and a one-cycle start pulse. The engine then fetches and executes commands in order until it reaches an end-of-program command, and it can raise an interrupt at that point.

Five kinds of command exist. One loads a write mask. One writes a register at a subsystem base plus an offset. One moves the fetch pointer by a signed byte distance. One waits for a hardware event flag and can consume it. One ends the program. Event inputs are latched into sticky flags, so a program can hold a register update until a moment such as vertical blanking has arrived, even if the event fired before the program reached the wait.

When the mask is partial, a write is done as a read-modify-write on the bus. When the mask is all ones, the write is a single bus write. An unknown command or an unknown subsystem stops the engine with an error.

Top module: `cmd_seq_engine`

## Requirements
- R1: After reset, busy, done, err and irq are 0 and no bus request is made. A start pulse while idle sets busy, clears done, err and irq, loads the fetch pointer from start_addr and sets the write mask to all ones.
- R2: A command is 64 bits at an 8-byte-aligned byte address. In the upper word, bits [31:24] hold the opcode, bits [23:16] the subsystem ID and bits [15:0] the offset or event ID. The lower word is the operand. The opcodes are 0x02 load mask, 0x04 write, 0x10 jump, 0x20 event wait and 0x40 end.
- R3: A write goes to bus address base + offset, where subsystem 1, 2 and 3 have bases 0x14000000, 0x14010000 and 0x14020000. Any other subsystem ID stops the engine with done, err and irq set, and no bus access is made.
- R4: While the mask is all ones, a write is one bus write of the operand, with no bus read.
- R5: While the mask is partial, a write first reads the register and then writes (old & ~mask) | (operand & mask). After every completed write the mask returns to all ones.
- R6: A jump adds the lower word, taken as a signed byte distance, to its own address. A distance of 8 continues with the next command, and negative distances go backward.
- R7: An event wait with operand bit 15 set stalls, making no bus access, until the flag for the event ID in bits [6:0] of the offset field is set. It then clears that flag only when operand bit 31 is set. Without bit 31 the flag stays set.
- R8: An event wait with operand bit 15 clear never stalls. With operand bit 31 set, it clears the named flag.
- R9: An event input that is high in any cycle sets its sticky flag, including while the engine is idle. A set in the same cycle as a clear wins.
- R10: The end command stops the engine with done set, busy clear and irq equal to operand bit 0.
- R11: An undefined opcode stops the engine with done, err and irq all set.
- R12: A start pulse while busy is ignored, and the running program continues unaffected.
- R13: A bus request stays high with address, direction and write data held stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| start_addr | input | AW | Byte address of the first command |
| cmd_addr | output | AW | Command memory byte address; data is expected one cycle later |
| cmd_data | input | 64 | Command word from memory |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid with bus_ack |
| bus_ack | input | 1 | Register bus acknowledge |
| ev_in | input | NUM_EV | Hardware event lines |
| busy | output | 1 | Engine is running |
| done | output | 1 | Program has stopped (end or error) |
| err | output | 1 | Program stopped on a bad command |
| irq | output | 1 | Interrupt request, held until the next start |

## Verification
The bench targets the mask lifecycle. It leaves a partial mask behind after an error, so a design that does not restore the mask on start, or after a write, produces a wrongly merged value or an extra bus read. Jump programs go forward by 8, forward past a command, and backward. A wrong sign extension or a wrong base address makes the skipped write appear or lands the jump on the wrong command. The event tests latch an event while the engine is idle, wait on it twice with and without consuming it, and then wait on a flag that an earlier program cleared. A design that loses sticky flags, clears without the update bit, or fails to clear would finish early or hang. A start pulse during a stall must not redirect the program.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam logic [7:0] OP_MASK  = 8'h02;
  localparam logic [7:0] OP_WRITE = 8'h04;
  localparam logic [7:0] OP_JUMP  = 8'h10;
  localparam logic [7:0] OP_WFE   = 8'h20;
  localparam logic [7:0] OP_EOC   = 8'h40;

  localparam int unsigned WAIT_BIT = 15;
  localparam int unsigned UPD_BIT  = 31;
  localparam int unsigned IRQ_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_EXEC, ST_READ, ST_WRITE, ST_WAIT
  } state_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  subsys;
    logic [15:0] field;
    logic [31:0] arg;
  } instr_t;

  function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic subsys_ok(input logic [7:0] id);
    return (id >= 8'd1) && (id <= 8'd3);
  endfunction

  function automatic logic [31:0] subsys_base(input logic [7:0] id);
    return 32'h1400_0000 + (({24'd0, id} - 32'd1) << 16);
  endfunction
endpackage

// File: rtl/cse_decode.sv
module cse_decode
  import cse_pkg::*;
(
  input  logic [7:0]  op,
  input  logic [7:0]  subsys,
  input  logic [15:0] field,
  input  logic        wait_bit,
  input  logic        upd_bit,
  output logic        is_mask,
  output logic        is_write,
  output logic        is_jump,
  output logic        is_wfe,
  output logic        is_bad,
  output logic        wait_en,
  output logic        upd_en,
  output logic [31:0] wr_addr
);
  always_comb begin
    is_mask  = 1'b0;
    is_write = 1'b0;
    is_jump  = 1'b0;
    is_wfe   = 1'b0;
    is_bad   = 1'b0;
    case (op)
      OP_MASK:  is_mask  = 1'b1;
      OP_WRITE: begin
        is_write = subsys_ok(subsys);
        is_bad   = !subsys_ok(subsys);
      end
      OP_JUMP:  is_jump  = 1'b1;
      OP_WFE:   is_wfe   = 1'b1;
      OP_EOC:   ;
      default:  is_bad   = 1'b1;
    endcase
  end

  assign wait_en = wait_bit;
  assign upd_en  = upd_bit;
  assign wr_addr = subsys_base(subsys) + {16'd0, field};
endmodule

// File: rtl/cse_event_flags.sv
module cse_event_flags #(
  parameter int unsigned NUM_EV = 128,
  localparam int unsigned EVW = $clog2(NUM_EV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              clr_en,
  input  logic [EVW-1:0]    clr_id,
  output logic [NUM_EV-1:0] flags
);
  logic [NUM_EV-1:0] clr_vec;
  logic [NUM_EV-1:0] keep_vec;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    assign clr_vec[i] = clr_en && (clr_id == EVW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= ev_in[i] | (flags[i] & ~clr_vec[i]);
    end
  end

  assign keep_vec = flags & ~clr_vec;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & $past(keep_vec)) == $past(keep_vec)); // R9
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & $past(ev_in)) == $past(ev_in)); // R9
endmodule

// File: rtl/cmd_seq_engine.sv
module cmd_seq_engine
  import cse_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned NUM_EV = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic [AW-1:0]     cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [31:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  input  logic [NUM_EV-1:0] ev_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq
);
  localparam int unsigned EVW = $clog2(NUM_EV);
  localparam logic [AW-1:0] STEP = AW'(8);

  state_e        state;
  instr_t        ir;
  logic [AW-1:0] pc;
  logic [31:0]   mask_r, addr_r, wdata_r;
  logic          done_r, err_r, irq_r;

  logic is_mask, is_write, is_jump, is_wfe, is_bad, wait_en, upd_en;
  logic [31:0]       wr_addr;
  logic [NUM_EV-1:0] flags;
  logic [EVW-1:0]    ev_id;
  logic [AW-1:0]     pc_next, pc_jump;

  // named events used by assertions
  logic ev_hit, rd_fire, wr_fire, clr_en, in_exec, in_wait;

  cse_decode i_decode (
    .op(ir.op), .subsys(ir.subsys), .field(ir.field),
    .wait_bit(ir.arg[WAIT_BIT]), .upd_bit(ir.arg[UPD_BIT]),
    .is_mask(is_mask), .is_write(is_write), .is_jump(is_jump),
    .is_wfe(is_wfe), .is_bad(is_bad), .wait_en(wait_en),
    .upd_en(upd_en), .wr_addr(wr_addr)
  );

  assign ev_id   = ir.field[EVW-1:0];
  assign ev_hit  = flags[ev_id];
  assign in_exec = (state == ST_EXEC);
  assign in_wait = (state == ST_WAIT);
  assign rd_fire = (state == ST_READ) && bus_ack;
  assign wr_fire = (state == ST_WRITE) && bus_ack;
  assign clr_en  = is_wfe && upd_en &&
                   ((in_exec && !wait_en) || (in_wait && ev_hit));
  assign pc_next = pc + STEP;
  assign pc_jump = pc + ir.arg[AW-1:0];

  cse_event_flags #(.NUM_EV(NUM_EV)) i_flags (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in),
    .clr_en(clr_en), .clr_id(ev_id), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ir      <= '0;
      pc      <= '0;
      mask_r  <= '1;
      addr_r  <= '0;
      wdata_r <= '0;
      done_r  <= 1'b0;
      err_r   <= 1'b0;
      irq_r   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pc     <= start_addr;
          mask_r <= '1;
          done_r <= 1'b0;
          err_r  <= 1'b0;
          irq_r  <= 1'b0;
          state  <= ST_FETCH;
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          ir    <= cmd_data;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_bad) begin
            done_r <= 1'b1;
            err_r  <= 1'b1;
            irq_r  <= 1'b1;
            state  <= ST_IDLE;
          end else if (is_mask) begin
            mask_r <= ir.arg;
            pc     <= pc_next;
            state  <= ST_FETCH;
          end else if (is_write) begin
            addr_r <= wr_addr;
            if (mask_r == '1) begin
              wdata_r <= ir.arg;
              state   <= ST_WRITE;
            end else begin
              state <= ST_READ;
            end
          end else if (is_jump) begin
            pc    <= pc_jump;
            state <= ST_FETCH;
          end else if (is_wfe) begin
            if (wait_en) state <= ST_WAIT;
            else begin
              pc    <= pc_next;
              state <= ST_FETCH;
            end
          end else begin
            done_r <= 1'b1;
            irq_r  <= ir.arg[IRQ_BIT];
            state  <= ST_IDLE;
          end
        end
        ST_READ: if (bus_ack) begin
          wdata_r <= merge_bits(bus_rdata, ir.arg, mask_r);
          state   <= ST_WRITE;
        end
        ST_WRITE: if (bus_ack) begin
          mask_r <= '1;
          pc     <= pc_next;
          state  <= ST_FETCH;
        end
        ST_WAIT: if (ev_hit) begin
          pc    <= pc_next;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_addr  = pc;
  assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_addr  = addr_r;
  assign bus_wdata = wdata_r;
  assign busy      = (state != ST_IDLE);
  assign done      = done_r;
  assign err       = err_r;
  assign irq       = irq_r;

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R13
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> irq && done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_MASK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mask_r == 32'hFFFF_FFFF)); // R5
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !bus_req); // R7
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_req && bus_we); // R5
endmodule

// File: tb/test_cmd_seq_engine.sv
module test_cmd_seq_engine;
  localparam int AW = 16;
  localparam int NUM_EV = 128;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0, cmd_addr;
  logic [63:0] cmd_data = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [NUM_EV-1:0] ev_in = '0;
  logic busy, done, err, irq;

  always #10 clk = ~clk; // 50 MHz

  cmd_seq_engine #(.AW(AW), .NUM_EV(NUM_EV)) i_cmd_seq_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .ev_in(ev_in),
    .busy(busy), .done(done), .err(err), .irq(irq));

  int checks = 0, errors = 0, n_writes = 0, n_reads = 0;
  bit fin = 1'b0;
  typedef struct { logic [31:0] a; logic [31:0] d; } exp_t;
  exp_t q[$];
  logic [63:0] mem [128];

  // R2: opcode [63:56], subsystem [55:48], offset/event [47:32], operand [31:0]
  function automatic logic [63:0] mk(input logic [7:0] op, input logic [7:0] sub,
                                     input logic [15:0] fld, input logic [31:0] arg);
    return {op, sub, fld, arg};
  endfunction

  function automatic logic [31:0] slave_val(input logic [31:0] a);
    return a ^ 32'hC3C3_5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.a = a; e.d = d;
    q.push_back(e);
  endtask

  // command memory: one-cycle read latency
  always @(posedge clk) cmd_data <= mem[cmd_addr[9:3]];

  // register bus slave: acks one cycle after request, read data is a function of address
  always @(posedge clk) begin
    bus_ack   <= bus_req && !bus_ack;
    bus_rdata <= slave_val(bus_addr);
  end

  // monitor / scoreboard
  logic hold_pend = 1'b0;
  logic [31:0] hold_addr;
  logic hold_we;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(bus_req && bus_addr == hold_addr && bus_we == hold_we, "R13 bus hold",
            {bus_we, bus_addr}, {hold_we, hold_addr});
      hold_pend = bus_req && !bus_ack;
      hold_addr = bus_addr;
      hold_we   = bus_we;
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          exp_t e;
          n_writes++;
          if (q.size() == 0) chk(1'b0, "R3 unexpected write", {bus_addr, bus_wdata}, 64'd0);
          else begin
            e = q.pop_front();
            chk(bus_addr == e.a && bus_wdata == e.d, "R3/R4/R5 write",
                {bus_addr, bus_wdata}, {e.a, e.d});
          end
        end else n_reads++;
      end
    end
  end

  task automatic pulse_ev(input int k);
    @(negedge clk); ev_in[k] = 1'b1;
    @(negedge clk); ev_in[k] = 1'b0;
  endtask

  task automatic launch(input logic [AW-1:0] a);
    @(negedge clk); start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_run();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    for (int i = 0; i < 128; i++) mem[i] = 64'd0;
    // program A at 0x000
    mem[0]   = mk(8'h04, 8'd1, 16'h0010, 32'h1111_2222);
    mem[1]   = mk(8'h02, 8'd0, 16'h0000, 32'h0000_FFFF);
    mem[2]   = mk(8'h04, 8'd2, 16'h0020, 32'hAAAA_BBBB);
    mem[3]   = mk(8'h04, 8'd3, 16'h0004, 32'h1234_5678);
    mem[4]   = mk(8'h40, 8'd0, 16'h0000, 32'h1);
    // jump program at 0x100
    mem[32]  = mk(8'h10, 8'd0, 16'h0, 32'd8);
    mem[33]  = mk(8'h10, 8'd0, 16'h0, 32'd24);
    mem[34]  = mk(8'h04, 8'd1, 16'h0008, 32'h7);
    mem[35]  = mk(8'h40, 8'd0, 16'h0, 32'h0);
    mem[36]  = mk(8'h10, 8'd0, 16'h0, 32'hFFFF_FFF0);
    // event program at 0x200
    mem[64]  = mk(8'h20, 8'd0, 16'd53, 32'h8000_8000);
    mem[65]  = mk(8'h04, 8'd2, 16'h0000, 32'h99);
    mem[66]  = mk(8'h20, 8'd0, 16'd11, 32'h8000_0000);
    mem[67]  = mk(8'h40, 8'd0, 16'h0, 32'h1);
    // wait on cleared flag at 0x280
    mem[80]  = mk(8'h20, 8'd0, 16'd11, 32'h8000_8000);
    mem[81]  = mk(8'h40, 8'd0, 16'h0, 32'h0);
    // sticky flag program at 0x300
    mem[96]  = mk(8'h20, 8'd0, 16'd63, 32'h0000_8000);
    mem[97]  = mk(8'h20, 8'd0, 16'd63, 32'h8000_8000);
    mem[98]  = mk(8'h04, 8'd3, 16'h000C, 32'h42);
    mem[99]  = mk(8'h40, 8'd0, 16'h0, 32'h1);
    // illegal opcode at 0x380
    mem[112] = mk(8'h02, 8'd0, 16'h0, 32'h0000_00FF);
    mem[113] = mk(8'h08, 8'd0, 16'h0, 32'h0);
    // bad subsystem at 0x3C0
    mem[120] = mk(8'h04, 8'd5, 16'h0, 32'h1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !irq && !bus_req, "R1 reset state",
        {busy, done, err, irq, bus_req}, 64'd0);

    // R11: undefined opcode, leaves a partial mask behind
    launch(16'h0380); finish_run();
    chk(done && err && irq, "R11 illegal opcode stop", {done, err, irq}, 3'b111);
    chk(n_writes == 0, "R11 no bus write", n_writes, 0);

    // R1/R4/R5/R3/R10/R2: program A
    r0 = n_reads;
    expect_wr(32'h1400_0010, 32'h1111_2222);
    expect_wr(32'h1401_0020, (slave_val(32'h1401_0020) & 32'hFFFF_0000) | (32'hAAAA_BBBB & 32'h0000_FFFF));
    expect_wr(32'h1402_0004, 32'h1234_5678);
    launch(16'h0000);
    chk(busy && !done && !err && !irq, "R1 start clears status", {busy, done, err, irq}, 4'b1000);
    finish_run();
    chk(n_reads - r0 == 1, "R4/R5 one read for partial mask only (R1 mask reset)", n_reads - r0, 1);
    chk(q.size() == 0, "R2 all writes issued", q.size(), 0);
    chk(done && !err && irq && !busy, "R10 end with irq", {done, err, irq, busy}, 4'b1010);

    // R6: jumps
    expect_wr(32'h1400_0008, 32'h7);
    launch(16'h0100); finish_run();
    chk(q.size() == 0 && done && !irq && !err, "R6 jump path and R10 no irq",
        {q.size(), done, irq, err}, {32'd0, 3'b100});

    // R3: bad subsystem
    w0 = n_writes; r0 = n_reads;
    launch(16'h03C0); finish_run();
    chk(err && done && irq && n_writes == w0 && n_reads == r0, "R3 bad subsystem",
        {err, done, irq}, 3'b111);

    // R9/R7: event latched while idle, waited on twice
    pulse_ev(63);
    expect_wr(32'h1402_000C, 32'h42);
    launch(16'h0300);
    repeat (30) @(negedge clk);
    chk(!busy && done && q.size() == 0, "R9 sticky flag, R7 no clear without update",
        {busy, done, q.size()}, {2'b01, 32'd0});

    // R7/R12/R8: stall, ignored start, clear-only wait
    pulse_ev(11);
    w0 = n_writes;
    expect_wr(32'h1401_0000, 32'h99);
    launch(16'h0200);
    repeat (20) @(negedge clk);
    chk(busy && n_writes == w0, "R7 stall until event", {busy, n_writes}, {1'b1, w0});
    launch(16'h0380);
    repeat (3) @(negedge clk);
    chk(busy && !done, "R12 start while busy ignored", {busy, done}, 2'b10);
    pulse_ev(53);
    finish_run();
    chk(done && !err && irq && q.size() == 0, "R12 program unaffected, R7 release",
        {done, err, irq, q.size()}, {3'b101, 32'd0});

    // R8: flag 11 was cleared without stalling, so a wait on it stalls
    launch(16'h0280);
    repeat (20) @(negedge clk);
    chk(busy, "R8 clear-only wait consumed flag", busy, 1);
    pulse_ev(11);
    finish_run();
    chk(done && !busy && !irq, "R8 wait released by new event", {done, busy, irq}, 3'b100);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule